// File: doc/BRIEF.md
# HD Video Standard Detector

This block identifies which high-definition raster a decoded serial video stream carries. It receives a one-cycle strobe for every end-of-active-video and start-of-active-video timing word, a frame-start marker, and the field (F) and vertical-blanking (V) bits decoded from the timing words. From these it measures, for each frame, the words per line, the lines per frame, the number of lines outside vertical blanking, and whether the field bit ever went high. It then maps that combination to a 4-bit standard code.

The clock is the word clock, so one clock equals one word of one channel. A line runs from one end-of-active strobe to the next. A frame begins at an end-of-active strobe that is accompanied by the frame-start marker. The code is updated only when two consecutive well-formed frames measure identically, so a single disturbed frame (a source switch, a dropped timing word) cannot make the reported standard flicker. Rates that differ only by the 1.001 factor give the same word and line counts and therefore share a code.

Top module: `vsd_std_detect`

## Requirements
- R1: Bit 3 of `std_code` is 1 exactly when the field bit sampled at some end-of-active strobe of the accepted frame was 1 (interlaced), and 0 when it was 0 on every line (progressive).
- R2: A progressive frame of 1650 words per line, 750 lines and 720 lines with V=0 gives code 0000.
- R3: A progressive frame of 1125 lines with 1080 lines at V=0 gives 0010 at 2200 words per line, 0100 at 2640 and 0110 at 2750.
- R4: A progressive frame that matches no entry of R2 or R3 gives 0111.
- R5: An interlaced frame of 1125 lines with 1080 lines at V=0 gives 1000 at 2200 words per line and 1010 at 2640.
- R6: An interlaced frame of 2376 words per line, 1250 lines and 1080 lines at V=0 gives 1100.
- R7: An interlaced frame of 2200 words per line, 1125 lines and only 1035 lines at V=0 gives 1110.
- R8: An interlaced frame that matches no entry of R5, R6 or R7 gives 1111.
- R9: A frame is closed by the next end-of-active strobe that carries the frame-start marker (the marker alone does nothing). `std_code` and `std_valid` change only when a closed frame is well formed and its measurement equals that of the frame closed just before it; then `std_valid` becomes 1 and stays 1 until reset. Otherwise both hold.
- R10: A frame in which any line has a different word count from the frame's first line, or any line does not contain exactly one start-of-active strobe, is not well formed: it never updates the code and the frame after it cannot update the code either.
- R11: While `rst_n` is low (synchronous, active low) `std_code` goes to 0000 and `std_valid` to 0.
- R12: The word and line counters saturate at their all-ones value instead of wrapping, so a line longer than the counter range is reported as unknown (0111 or 1111), never as a known standard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eav_stb | input | 1 | One-cycle strobe on each end-of-active timing word |
| sav_stb | input | 1 | One-cycle strobe on each start-of-active timing word |
| frame_stb | input | 1 | Marks the end-of-active strobe that opens line 1 of a frame |
| f_bit | input | 1 | Field bit decoded from the current timing word |
| v_bit | input | 1 | Vertical-blanking bit decoded from the current timing word |
| std_code | output | 4 | Detected standard code |
| std_valid | output | 1 | A code has been accepted since reset |

## Verification
The bench runs scaled-down rasters so that every table entry, including the 1035-active interlaced one that differs from its neighbour only in the active count, is reached; a classifier that ignored the active count would report 1000 where 1110 is expected. It proves the two-frame agreement by showing that a single different frame, the first frame after reset, and a good frame followed by a frame with one stretched line or one missing start-of-active strobe all leave the code untouched; a design that accepted on one frame or trusted only the last line's length would change it. It drives a line longer than the word counter can hold, where a wrapping counter would alias onto the 720p entry and report 0000 instead of 0111.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [3:0] {
    STD_P720     = 4'b0000,
    STD_P1080_30 = 4'b0010,
    STD_P1080_25 = 4'b0100,
    STD_P1080_24 = 4'b0110,
    STD_P_UNK    = 4'b0111,
    STD_I1080_30 = 4'b1000,
    STD_I1080_25 = 4'b1010,
    STD_I1250    = 4'b1100,
    STD_I1035    = 4'b1110,
    STD_I_UNK    = 4'b1111
  } std_code_e;

endpackage

// File: rtl/vsd_line_meas.sv
module vsd_line_meas #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eav_stb,
  input  logic              sav_stb,
  output logic [WORD_W-1:0] line_len,
  output logic              line_ok
);

  localparam logic [WORD_W-1:0] WMAX = {WORD_W{1'b1}};

  logic [WORD_W-1:0] wcnt;
  logic [1:0]        sav_cnt;
  logic              have_eav;

  function automatic logic [WORD_W-1:0] sat_inc(input logic [WORD_W-1:0] x);
    return (x == WMAX) ? WMAX : x + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt     <= '0;
      sav_cnt  <= '0;
      have_eav <= 1'b0;
    end else if (eav_stb) begin
      wcnt     <= '0;
      sav_cnt  <= '0;
      have_eav <= 1'b1;
    end else begin
      wcnt <= sat_inc(wcnt);
      if (sav_stb && sav_cnt != 2'd2) sav_cnt <= sav_cnt + 2'd1;
    end
  end

  // Length of the line closed by an end-of-active strobe in this cycle.
  assign line_len = sat_inc(wcnt);
  assign line_ok  = have_eav && (sav_cnt == 2'd1);

  AST_WCNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!eav_stb && wcnt == WMAX) |=> (wcnt == WMAX)) else $error("word counter wrapped"); // R12

endmodule

// File: rtl/vsd_frame_meas.sv
module vsd_frame_meas #(
  parameter int WORD_W = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eav_stb,
  input  logic              frame_stb,
  input  logic              f_bit,
  input  logic              v_bit,
  input  logic [WORD_W-1:0] line_len,
  input  logic              line_ok,
  output logic              frame_done,
  output logic [WORD_W-1:0] m_words,
  output logic [LINE_W-1:0] m_lines,
  output logic [LINE_W-1:0] m_active,
  output logic              m_ilace,
  output logic              m_regular
);

  localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

  logic              in_frame;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] act_cnt;
  logic              f_seen;
  logic [WORD_W-1:0] ref_len;
  logic              have_ref;
  logic              irreg;

  logic              len_mismatch;
  logic              close_bad;
  logic              frame_eav;

  function automatic logic [LINE_W-1:0] lsat_inc(input logic [LINE_W-1:0] x);
    return (x == LMAX) ? LMAX : x + 1'b1;
  endfunction

  assign len_mismatch = have_ref && (line_len != ref_len);
  assign close_bad    = !line_ok || len_mismatch;
  assign frame_eav    = eav_stb && frame_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      line_cnt   <= '0;
      act_cnt    <= '0;
      f_seen     <= 1'b0;
      ref_len    <= '0;
      have_ref   <= 1'b0;
      irreg      <= 1'b0;
      frame_done <= 1'b0;
      m_words    <= '0;
      m_lines    <= '0;
      m_active   <= '0;
      m_ilace    <= 1'b0;
      m_regular  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (frame_eav) begin
        if (in_frame) begin
          frame_done <= 1'b1;
          m_words    <= have_ref ? ref_len : line_len;
          m_lines    <= line_cnt;
          m_active   <= act_cnt;
          m_ilace    <= f_seen;
          m_regular  <= !(irreg || close_bad);
        end
        in_frame <= 1'b1;
        line_cnt <= {{(LINE_W-1){1'b0}}, 1'b1};
        act_cnt  <= {{(LINE_W-1){1'b0}}, !v_bit};
        f_seen   <= f_bit;
        have_ref <= 1'b0;
        irreg    <= 1'b0;
      end else if (eav_stb && in_frame) begin
        if (!have_ref) begin
          ref_len  <= line_len;
          have_ref <= 1'b1;
        end
        irreg    <= irreg || close_bad;
        line_cnt <= lsat_inc(line_cnt);
        if (!v_bit) act_cnt <= lsat_inc(act_cnt);
        f_seen   <= f_seen || f_bit;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eav_stb && !frame_stb && in_frame) |=> (line_cnt >= $past(line_cnt))) else $error("line counter wrapped"); // R12
  AST_DONE_ON_FRAME_EAV: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(eav_stb && frame_stb)) else $error("frame closed without marked strobe"); // R9

endmodule

// File: rtl/vsd_classify.sv
module vsd_classify
  import vsd_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int LINE_W     = 11,
  parameter int W_720      = 1650,
  parameter int W_1080_30  = 2200,
  parameter int W_1080_25  = 2640,
  parameter int W_1080_24  = 2750,
  parameter int W_1250     = 2376,
  parameter int L_720      = 750,
  parameter int L_1125     = 1125,
  parameter int L_1250     = 1250,
  parameter int A_720      = 720,
  parameter int A_1035     = 1035,
  parameter int A_1080     = 1080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] m_words,
  input  logic [LINE_W-1:0] m_lines,
  input  logic [LINE_W-1:0] m_active,
  input  logic              m_ilace,
  input  logic              m_regular,
  output logic [3:0]        std_code,
  output logic              std_valid
);

  localparam logic [WORD_W-1:0] KW_720 = WORD_W'(W_720);
  localparam logic [WORD_W-1:0] KW_30  = WORD_W'(W_1080_30);
  localparam logic [WORD_W-1:0] KW_25  = WORD_W'(W_1080_25);
  localparam logic [WORD_W-1:0] KW_24  = WORD_W'(W_1080_24);
  localparam logic [WORD_W-1:0] KW_50  = WORD_W'(W_1250);
  localparam logic [LINE_W-1:0] KL_720 = LINE_W'(L_720);
  localparam logic [LINE_W-1:0] KL_112 = LINE_W'(L_1125);
  localparam logic [LINE_W-1:0] KL_125 = LINE_W'(L_1250);
  localparam logic [LINE_W-1:0] KA_720 = LINE_W'(A_720);
  localparam logic [LINE_W-1:0] KA_103 = LINE_W'(A_1035);
  localparam logic [LINE_W-1:0] KA_108 = LINE_W'(A_1080);

  function automatic std_code_e classify(
    input logic [WORD_W-1:0] w,
    input logic [LINE_W-1:0] l,
    input logic [LINE_W-1:0] a,
    input logic              il
  );
    std_code_e c;
    logic hd1080;
    hd1080 = (l == KL_112) && (a == KA_108);
    if (!il) begin
      c = STD_P_UNK;
      if (w == KW_720 && l == KL_720 && a == KA_720) c = STD_P720;
      else if (hd1080 && w == KW_30)                  c = STD_P1080_30;
      else if (hd1080 && w == KW_25)                  c = STD_P1080_25;
      else if (hd1080 && w == KW_24)                  c = STD_P1080_24;
    end else begin
      c = STD_I_UNK;
      if (hd1080 && w == KW_30)                                  c = STD_I1080_30;
      else if (hd1080 && w == KW_25)                             c = STD_I1080_25;
      else if (w == KW_50 && l == KL_125 && a == KA_108)         c = STD_I1250;
      else if (w == KW_30 && l == KL_112 && a == KA_103)         c = STD_I1035;
    end
    return c;
  endfunction

  logic [WORD_W-1:0] p_words;
  logic [LINE_W-1:0] p_lines;
  logic [LINE_W-1:0] p_active;
  logic              p_ilace;
  logic              p_ok;
  std_code_e         code_q;

  logic same_meas;
  logic accept;

  assign same_meas = p_ok && (p_words == m_words) && (p_lines == m_lines) &&
                     (p_active == m_active) && (p_ilace == m_ilace);
  assign accept    = frame_done && m_regular && same_meas;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_words   <= '0;
      p_lines   <= '0;
      p_active  <= '0;
      p_ilace   <= 1'b0;
      p_ok      <= 1'b0;
      code_q    <= STD_P720;
      std_valid <= 1'b0;
    end else begin
      if (frame_done) begin
        p_words  <= m_words;
        p_lines  <= m_lines;
        p_active <= m_active;
        p_ilace  <= m_ilace;
        p_ok     <= m_regular;
      end
      if (accept) begin
        code_q    <= classify(m_words, m_lines, m_active, m_ilace);
        std_valid <= 1'b1;
      end
    end
  end

  assign std_code = code_q;

  AST_CODE_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(std_code)) else $error("code changed between frames"); // R9
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    std_valid |=> std_valid) else $error("valid dropped"); // R9
  AST_IRREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !m_regular) |=> ($stable(std_code) && $stable(std_valid))) else $error("bad frame updated code"); // R10
  AST_BIT3_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(std_code) |-> ($past(frame_done) && (std_code[3] == $past(m_ilace)))) else $error("scan bit mismatch"); // R1

endmodule

// File: rtl/vsd_std_detect.sv
module vsd_std_detect #(
  parameter int WORD_W    = 12,
  parameter int LINE_W    = 11,
  parameter int W_720     = 1650,
  parameter int W_1080_30 = 2200,
  parameter int W_1080_25 = 2640,
  parameter int W_1080_24 = 2750,
  parameter int W_1250    = 2376,
  parameter int L_720     = 750,
  parameter int L_1125    = 1125,
  parameter int L_1250    = 1250,
  parameter int A_720     = 720,
  parameter int A_1035    = 1035,
  parameter int A_1080    = 1080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eav_stb,
  input  logic       sav_stb,
  input  logic       frame_stb,
  input  logic       f_bit,
  input  logic       v_bit,
  output logic [3:0] std_code,
  output logic       std_valid
);

  logic [WORD_W-1:0] line_len;
  logic              line_ok;
  logic              frame_done;
  logic [WORD_W-1:0] m_words;
  logic [LINE_W-1:0] m_lines;
  logic [LINE_W-1:0] m_active;
  logic              m_ilace;
  logic              m_regular;

  vsd_line_meas #(.WORD_W(WORD_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .eav_stb  (eav_stb),
    .sav_stb  (sav_stb),
    .line_len (line_len),
    .line_ok  (line_ok)
  );

  vsd_frame_meas #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .eav_stb    (eav_stb),
    .frame_stb  (frame_stb),
    .f_bit      (f_bit),
    .v_bit      (v_bit),
    .line_len   (line_len),
    .line_ok    (line_ok),
    .frame_done (frame_done),
    .m_words    (m_words),
    .m_lines    (m_lines),
    .m_active   (m_active),
    .m_ilace    (m_ilace),
    .m_regular  (m_regular)
  );

  vsd_classify #(
    .WORD_W(WORD_W), .LINE_W(LINE_W),
    .W_720(W_720), .W_1080_30(W_1080_30), .W_1080_25(W_1080_25),
    .W_1080_24(W_1080_24), .W_1250(W_1250),
    .L_720(L_720), .L_1125(L_1125), .L_1250(L_1250),
    .A_720(A_720), .A_1035(A_1035), .A_1080(A_1080)
  ) u_class (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .m_words    (m_words),
    .m_lines    (m_lines),
    .m_active   (m_active),
    .m_ilace    (m_ilace),
    .m_regular  (m_regular),
    .std_code   (std_code),
    .std_valid  (std_valid)
  );

endmodule

// File: tb/tb_vsd_std_detect.sv
module tb_vsd_std_detect;

  // Scaled raster: words 16/22/24/26/28 stand for 1650/2200/2376/2640/2750,
  // lines 8/12/14 for 750/1125/1250, active 6/9/10 for 720/1035/1080.
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eav_stb = 1'b0;
  logic       sav_stb = 1'b0;
  logic       frame_stb = 1'b0;
  logic       f_bit = 1'b0;
  logic       v_bit = 1'b0;
  logic [3:0] std_code;
  logic       std_valid;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  vsd_std_detect #(
    .WORD_W(6), .LINE_W(5),
    .W_720(16), .W_1080_30(22), .W_1080_25(26), .W_1080_24(28), .W_1250(24),
    .L_720(8), .L_1125(12), .L_1250(14),
    .A_720(6), .A_1035(9), .A_1080(10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .eav_stb(eav_stb), .sav_stb(sav_stb),
    .frame_stb(frame_stb), .f_bit(f_bit), .v_bit(v_bit),
    .std_code(std_code), .std_valid(std_valid)
  );

  // words, lines, active, interlaced, expected code
  localparam int NVEC = 13;
  localparam int VEC [NVEC][5] = '{
    '{16,  8,  6, 0, 4'b0000},
    '{22, 12, 10, 0, 4'b0010},
    '{26, 12, 10, 0, 4'b0100},
    '{28, 12, 10, 0, 4'b0110},
    '{22, 12,  9, 0, 4'b0111},
    '{16, 12, 10, 0, 4'b0111},
    '{24, 12, 10, 0, 4'b0111},
    '{22, 12, 10, 1, 4'b1000},
    '{26, 12, 10, 1, 4'b1010},
    '{24, 14, 10, 1, 4'b1100},
    '{22, 12,  9, 1, 4'b1110},
    '{28, 12, 10, 1, 4'b1111},
    '{16,  8,  6, 1, 4'b1111}
  };

  function automatic string req_of(input int code);
    case (code)
      4'b0000: return "R2";
      4'b0010, 4'b0100, 4'b0110: return "R3";
      4'b0111: return "R4";
      4'b1000, 4'b1010: return "R5";
      4'b1100: return "R6";
      4'b1110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic [3:0] got_c, input logic [3:0] exp_c,
                       input logic got_v, input logic exp_v, input string req);
    checks++;
    if (got_c !== exp_c || got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: code=%b valid=%b expected code=%b valid=%b",
               req, got_c, got_v, exp_c, exp_v);
    end
  endtask

  // bad: 0 none, 1 line 3 one word longer, 2 line 3 has no start-of-active
  task automatic send_frame(input int words, input int lines, input int active,
                            input int ilace, input int bad);
    for (int ln = 0; ln < lines; ln++) begin
      int wl;
      wl = words + ((bad == 1 && ln == 3) ? 1 : 0);
      for (int c = 0; c < wl; c++) begin
        @(negedge clk);
        eav_stb   = (c == 0);
        frame_stb = (c == 0 && ln == 0);
        sav_stb   = (c == 2) && !(bad == 2 && ln == 3);
        v_bit     = (ln >= active);
        f_bit     = (ilace != 0) && (ln >= lines / 2);
      end
    end
  endtask

  task automatic close_frame();
    @(negedge clk);
    eav_stb = 1'b1; frame_stb = 1'b1; sav_stb = 1'b0; v_bit = 1'b0; f_bit = 1'b0;
    @(negedge clk);
    eav_stb = 1'b0; frame_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] last;
    repeat (5) @(negedge clk);
    check(std_code, 4'b0000, std_valid, 1'b0, "R11 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R9: only one complete frame since reset, nothing accepted
    send_frame(22, 12, 10, 0, 0);
    close_frame();
    check(std_code, 4'b0000, std_valid, 1'b0, "R9 single frame after reset");

    // Table walk: two identical frames then close; bit 3 covers R1
    last = 4'b0000;
    for (int i = 0; i < NVEC; i++) begin
      send_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0);
      send_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0);
      close_frame();
      check(std_code, VEC[i][4][3:0], std_valid, 1'b1, req_of(VEC[i][4]));
      check({std_code[3], 3'b000}, {VEC[i][3] != 0, 3'b000}, std_valid, 1'b1, "R1 scan bit");
      last = VEC[i][4][3:0];
    end

    // R9: one different frame does not change the code
    send_frame(16, 8, 6, 0, 0);
    close_frame();
    check(std_code, last, std_valid, 1'b1, "R9 hold on single new frame");
    send_frame(16, 8, 6, 0, 0);
    send_frame(16, 8, 6, 0, 0);
    close_frame();
    check(std_code, 4'b0000, std_valid, 1'b1, "R9 update on agreement");

    // R10: good frame followed by a stretched-line frame
    send_frame(22, 12, 10, 0, 0);
    send_frame(22, 12, 10, 0, 1);
    close_frame();
    check(std_code, 4'b0000, std_valid, 1'b1, "R10 uneven line length");
    // R10: good frame followed by a frame with a line missing its SAV
    send_frame(22, 12, 10, 0, 0);
    send_frame(22, 12, 10, 0, 2);
    close_frame();
    check(std_code, 4'b0000, std_valid, 1'b1, "R10 missing start-of-active");
    // R10: a bad frame cannot serve as the first of an agreeing pair
    send_frame(22, 12, 10, 0, 1);
    send_frame(22, 12, 10, 0, 0);
    close_frame();
    check(std_code, 4'b0000, std_valid, 1'b1, "R10 bad frame then good frame");
    send_frame(22, 12, 10, 0, 0);
    send_frame(22, 12, 10, 0, 0);
    close_frame();
    check(std_code, 4'b0010, std_valid, 1'b1, "R10 recovery with good pair");

    // R12: 80-word lines overflow a 6-bit counter; wrap would alias to 16
    send_frame(80, 8, 6, 0, 0);
    send_frame(80, 8, 6, 0, 0);
    close_frame();
    check(std_code, 4'b0111, std_valid, 1'b1, "R12 saturated word count");

    // R11: reset after lock
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(std_code, 4'b0000, std_valid, 1'b0, "R11 reset after lock");
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule